// File: doc/BRIEF.md
# Real Power Multiply-and-Filter Path

This block turns a stream of paired converter samples (one signed word from the current channel, one from the voltage channel) into a stream of signed real-power words for the pulse generators that follow it. On the current side it first applies a selectable digital gain. It then applies an optional DC-removing high-pass stage. A half-sample interpolation keeps the current channel in step with the voltage channel, and it runs only while the high-pass stage is on. The two aligned samples are multiplied. A single-pole low-pass stage then keeps only the slowly varying term of the product, which is the average real power.

Samples enter and leave through a valid/ready stream. A pair is taken in on a rising clock edge where `in_valid` and `in_ready` are both high. The high-pass enable and the gain code are sampled with that pair and travel with it. The three-stage pipeline advances only when its output register is empty or is being read, so `in_ready` is low exactly when `out_valid` is high and `out_ready` is low. While stalled, the output word is held and no filter state changes. Bubbles, meaning cycles with no accepted input, leave every filter state untouched.

Top module: `rpw_power_path`

## Requirements
- R1: `in_ready` is high whenever `out_valid` is low or `out_ready` is high, and low whenever `out_valid` is high while `out_ready` is low.
- R2: With `out_ready` held high, an accepted pair produces its `out_valid` beat on the third rising edge counting the accepting edge. Each accepted pair yields exactly one output beat, and beats leave in acceptance order.
- R3: `gain_sel` codes 2'b00, 2'b01, 2'b10 and 2'b11 multiply the current sample by 1, 2, 8 and 16. The result is saturated to the signed DW-bit range.
- R4: With `hp_en` = 1 the high-pass output is sat(g − d), where g is the gained sample and d is the DC estimate. The estimate then becomes sat(d + ((g − d) >>> HPF_SHIFT)), using an arithmetic shift. With `hp_en` = 0 the gained sample passes unchanged and d is cleared to zero.
- R5: With `hp_en` = 1 the aligned current is (c + c_prev) >>> 1, where c_prev is the previous accepted high-pass output. With `hp_en` = 0 the current passes unchanged. In both modes c_prev is updated on every accepted pair.
- R6: The product p = aligned current × voltage sample is a full-width 2·DW-bit signed product. The output accumulator a becomes sat(a + ((p − a) >>> LPF_SHIFT)), and `power` shows a.
- R7: Synchronous reset clears the DC estimate, the previous-current register, the accumulator and all valid flags. After reset `out_valid` is 0 and `in_ready` is 1.
- R8: While `out_valid` = 1 and `out_ready` = 0, `out_valid` stays high and `power` keeps its value on the next cycle.
- R9: Cycles with no accepted input, and stall cycles, change no filter state. The output sequence depends only on the sequence of accepted pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pair present |
| in_ready | output | 1 | Pipeline can take a pair this cycle |
| cur_in | input | DW | Signed current-channel sample |
| volt_in | input | DW | Signed voltage-channel sample |
| hp_en | input | 1 | 1 = high-pass and alignment on, 0 = bypass |
| gain_sel | input | 2 | Current gain code (×1, ×2, ×8, ×16) |
| out_valid | output | 1 | Power word present |
| out_ready | input | 1 | Consumer takes the power word |
| power | output | 2·DW | Signed filtered real power |

## Verification
The hardest case to reach from the ports is a stall that lands while bubbles sit in the middle of the pipeline, with the mode and gain changing between accepted pairs. Here a filter that stepped on an empty or held slot would drift without any visible glitch. The stimulus reaches this case with a pseudo-random pattern that toggles `in_valid` and `out_ready` independently and draws a new gain code and high-pass setting for every pair. Every beat is compared with a bench model that advances only on accepted pairs. Short filter shifts make each misstep show up within a few samples.

// File: rtl/rpw_pkg.sv
package rpw_pkg;

  // Current-channel gain codes; the code-to-gain mapping is behavioural.
  typedef enum logic [1:0] {
    GAIN_X1  = 2'b00,
    GAIN_X2  = 2'b01,
    GAIN_X8  = 2'b10,
    GAIN_X16 = 2'b11
  } gain_sel_e;

  function automatic logic [2:0] gain_shift(input gain_sel_e g);
    logic [2:0] s;
    unique case (g)
      GAIN_X1:  s = 3'd0;
      GAIN_X2:  s = 3'd1;
      GAIN_X8:  s = 3'd3;
      GAIN_X16: s = 3'd4;
      default:  s = 3'd0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/rpw_current_front.sv
module rpw_current_front
  import rpw_pkg::*;
#(
  parameter int DW = 16,
  parameter int HK = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 adv,
  input  logic                 v_in,
  input  logic                 hp,
  input  logic [1:0]           gain,
  input  logic signed [DW-1:0] x,
  input  logic signed [DW-1:0] volt,
  output logic                 v_out,
  output logic                 hp_q,
  output logic signed [DW-1:0] cur_q,
  output logic signed [DW-1:0] volt_q
);

  localparam int EW = DW + 5;
  localparam logic signed [EW-1:0] HI = (EW'(1) <<< (DW - 1)) - EW'(1);
  localparam logic signed [EW-1:0] LO = -(EW'(1) <<< (DW - 1));

  logic        [2:0]    sh;
  logic signed [EW-1:0] xe;
  logic signed [EW-1:0] scaled;
  logic signed [DW-1:0] gx;
  logic signed [DW-1:0] dc;
  logic signed [DW:0]   diff;
  logic signed [DW-1:0] hpo;
  logic signed [DW:0]   step;
  logic signed [DW:0]   dc_sum;
  logic signed [DW-1:0] dc_nx;
  logic                 take;

  assign take = adv && v_in;

  // Gain stage: widen, shift, clamp.
  assign sh     = gain_shift(gain_sel_e'(gain));
  assign xe     = EW'(x);
  assign scaled = xe <<< sh;
  assign gx     = (scaled > HI) ? HI[DW-1:0] :
                  (scaled < LO) ? LO[DW-1:0] : scaled[DW-1:0];

  // DC-removal stage.
  assign diff   = (DW+1)'(gx) - (DW+1)'(dc);
  assign hpo    = (diff[DW] != diff[DW-1]) ? {diff[DW], {(DW-1){~diff[DW]}}}
                                           : diff[DW-1:0];
  assign step   = diff >>> HK;
  assign dc_sum = (DW+1)'(dc) + step;
  assign dc_nx  = (dc_sum[DW] != dc_sum[DW-1]) ? {dc_sum[DW], {(DW-1){~dc_sum[DW]}}}
                                               : dc_sum[DW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      v_out  <= 1'b0;
      hp_q   <= 1'b0;
      cur_q  <= '0;
      volt_q <= '0;
      dc     <= '0;
    end else if (adv) begin
      v_out <= v_in;
      if (v_in) begin
        hp_q   <= hp;
        cur_q  <= hp ? hpo : gx;
        volt_q <= volt;
        dc     <= hp ? dc_nx : '0;
      end
    end
  end

  // R4: bypassed pair leaves the DC estimate at zero
  assert_bypass_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (take && !hp) |=> (dc == '0));

  // R3: unity code in bypass passes the sample unchanged
  assert_unity_gain_R3: assert property (@(posedge clk) disable iff (rst)
    (take && !hp && gain == 2'b00) |=> (cur_q == $past(x)));

  // R9: no accepted pair, no change of the DC estimate
  assert_dc_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (!take) |=> $stable(dc));

endmodule

// File: rtl/rpw_phase_align.sv
module rpw_phase_align #(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 adv,
  input  logic                 v_in,
  input  logic                 hp,
  input  logic signed [DW-1:0] cur,
  input  logic signed [DW-1:0] volt,
  output logic                 v_out,
  output logic signed [DW-1:0] cur_q,
  output logic signed [DW-1:0] volt_q
);

  logic signed [DW-1:0] prev;
  logic signed [DW:0]   sum;
  logic signed [DW:0]   half;
  logic signed [DW-1:0] mid;

  assign sum  = (DW+1)'(cur) + (DW+1)'(prev);
  assign half = sum >>> 1;
  assign mid  = (half[DW] != half[DW-1]) ? {half[DW], {(DW-1){~half[DW]}}}
                                         : half[DW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      v_out  <= 1'b0;
      prev   <= '0;
      cur_q  <= '0;
      volt_q <= '0;
    end else if (adv) begin
      v_out <= v_in;
      if (v_in) begin
        prev   <= cur;
        cur_q  <= hp ? mid : cur;
        volt_q <= volt;
      end
    end
  end

  // R5: bypass mode forwards the current sample untouched
  assert_align_bypass_R5: assert property (@(posedge clk) disable iff (rst)
    (adv && v_in && !hp) |=> (cur_q == $past(cur)));

  // R2: an occupied slot moves on when the pipeline advances
  assert_slot_moves_R2: assert property (@(posedge clk) disable iff (rst)
    (adv && v_in) |=> v_out);

endmodule

// File: rtl/rpw_mult_lpf.sv
module rpw_mult_lpf #(
  parameter int DW = 16,
  parameter int LK = 8,
  parameter int PW = 2 * DW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 adv,
  input  logic                 v_in,
  input  logic signed [DW-1:0] cur,
  input  logic signed [DW-1:0] volt,
  output logic                 v_out,
  output logic signed [PW-1:0] acc
);

  logic signed [2*DW-1:0] prod;
  logic signed [PW:0]     pe;
  logic signed [PW:0]     ae;
  logic signed [PW:0]     diff;
  logic signed [PW:0]     nxt;
  logic signed [PW-1:0]   nxt_sat;

  assign prod    = cur * volt;
  assign pe      = (PW+1)'(prod);
  assign ae      = (PW+1)'(acc);
  assign diff    = pe - ae;
  assign nxt     = ae + (diff >>> LK);
  assign nxt_sat = (nxt[PW] != nxt[PW-1]) ? {nxt[PW], {(PW-1){~nxt[PW]}}}
                                          : nxt[PW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      v_out <= 1'b0;
      acc   <= '0;
    end else if (adv) begin
      v_out <= v_in;
      if (v_in) acc <= nxt_sat;
    end
  end

  // R6: accumulator never moves away from a product at or above it
  assert_lpf_toward_R6: assert property (@(posedge clk) disable iff (rst)
    (adv && v_in && pe >= ae) |=> (acc >= $past(acc)));

  // R9: accumulator frozen without an accepted slot
  assert_lpf_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !(adv && v_in) |=> $stable(acc));

endmodule

// File: rtl/rpw_power_path.sv
module rpw_power_path
  import rpw_pkg::*;
#(
  parameter int DW        = 16,
  parameter int HPF_SHIFT = 10,
  parameter int LPF_SHIFT = 8,
  localparam int PW       = 2 * DW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] cur_in,
  input  logic signed [DW-1:0] volt_in,
  input  logic                 hp_en,
  input  logic [1:0]           gain_sel,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [PW-1:0] power
);

  logic                 adv;
  logic                 v1, v2, hp1;
  logic signed [DW-1:0] c1, u1, c2, u2;

  // Whole pipeline moves together; output slot gates it.
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  rpw_current_front #(.DW(DW), .HK(HPF_SHIFT)) u_front (
    .clk(clk), .rst(rst), .adv(adv), .v_in(in_valid), .hp(hp_en),
    .gain(gain_sel), .x(cur_in), .volt(volt_in),
    .v_out(v1), .hp_q(hp1), .cur_q(c1), .volt_q(u1)
  );

  rpw_phase_align #(.DW(DW)) u_align (
    .clk(clk), .rst(rst), .adv(adv), .v_in(v1), .hp(hp1),
    .cur(c1), .volt(u1),
    .v_out(v2), .cur_q(c2), .volt_q(u2)
  );

  rpw_mult_lpf #(.DW(DW), .LK(LPF_SHIFT), .PW(PW)) u_lpf (
    .clk(clk), .rst(rst), .adv(adv), .v_in(v2),
    .cur(c2), .volt(u2),
    .v_out(out_valid), .acc(power)
  );

  // R1: a held output blocks the input side
  assert_backpressure_R1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R8: a stalled beat is held unchanged
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(power)));

  // R7: reset empties the output slot
  assert_reset_empty_R7: assert property (@(posedge clk)
    rst |=> !out_valid);

endmodule

// File: tb/rpw_power_path_test.sv
`timescale 1ns/1ps
module rpw_power_path_test;

  localparam int DW = 16;
  localparam int HK = 4;
  localparam int LK = 3;
  localparam int QN = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [DW-1:0] cur_in = '0;
  logic signed [DW-1:0] volt_in = '0;
  logic hp_en = 1'b0;
  logic [1:0] gain_sel = 2'b00;
  logic out_valid;
  logic out_ready = 1'b1;
  logic signed [2*DW-1:0] power;

  always #10 clk = ~clk;  // 50 MHz

  rpw_power_path #(.DW(DW), .HPF_SHIFT(HK), .LPF_SHIFT(LK)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .cur_in(cur_in), .volt_in(volt_in), .hp_en(hp_en), .gain_sel(gain_sel),
    .out_valid(out_valid), .out_ready(out_ready), .power(power)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Reference model state
  longint m_dc, m_prev, m_acc;
  longint exp_q[QN];
  string  tag_q[QN];
  int wr = 0, rd = 0;
  bit stall_prev = 0;
  longint held = 0;
  bit popped = 0;
  logic [31:0] rng = 32'h1234_5678;

  function automatic longint satw(input longint v, input int w);
    longint hi = (longint'(1) <<< (w - 1)) - 1;
    longint lo = -(longint'(1) <<< (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] t = s;
    t = t ^ (t << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Model of one accepted pair (R3, R4, R5, R6)
  task automatic model(input int x, input int v, input int g, input bit hp, input string req);
    longint mul, gx, c, cc, d, p;
    mul = (g == 0) ? 1 : (g == 1) ? 2 : (g == 2) ? 8 : 16;
    gx = satw(longint'(x) * mul, DW);
    if (hp) begin
      d = gx - m_dc;
      c = satw(d, DW);
      m_dc = satw(m_dc + (d >>> HK), DW);
      cc = satw((c + m_prev) >>> 1, DW);
    end else begin
      c = gx;
      m_dc = 0;
      cc = c;
    end
    m_prev = c;
    p = cc * longint'(v);
    m_acc = satw(m_acc + ((p - m_acc) >>> LK), 2 * DW);
    exp_q[wr % QN] = m_acc;
    tag_q[wr % QN] = req;
    wr++;
  endtask

  task automatic step(input bit iv, input int x, input int v, input int g,
                      input bit hp, input bit ordy, input string req);
    @(negedge clk);
    in_valid = iv;
    cur_in = DW'(x);
    volt_in = DW'(v);
    gain_sel = 2'(g);
    hp_en = hp;
    out_ready = ordy;
    #1;
    popped = 0;
    if (stall_prev) begin
      check(out_valid == 1'b1, "R8", longint'(out_valid), 1);
      check(longint'(power) == held, "R8", longint'(power), held);
    end
    if (out_valid && !out_ready) begin
      check(in_ready == 1'b0, "R1", longint'(in_ready), 0);
      stall_prev = 1;
      held = longint'(power);
    end else begin
      stall_prev = 0;
      check(in_ready == 1'b1, "R1", longint'(in_ready), 1);
    end
    if (out_valid && out_ready) begin
      if (rd == wr) begin
        check(0, "R2", 1, 0);
      end else begin
        check(longint'(power) == exp_q[rd % QN], tag_q[rd % QN],
              longint'(power), exp_q[rd % QN]);
        rd++;
      end
      popped = 1;
    end
    if (in_valid && in_ready) model(x, v, g, hp, req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_dc = 0; m_prev = 0; m_acc = 0;
    rd = 0; wr = 0; stall_prev = 0;
    #1;
    check(out_valid == 1'b0, "R7", longint'(out_valid), 0);
    check(in_ready == 1'b1, "R7", longint'(in_ready), 1);
  endtask

  task automatic drain();
    for (int i = 0; i < 12; i++) step(0, 0, 0, 0, 0, 1, "R2");
    check(rd == wr, "R2", rd, wr);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #4_000_000;
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    m_dc = 0; m_prev = 0; m_acc = 0;
    do_reset();

    // R2: latency of a lone pair
    begin
      int n;
      step(1, 1000, 2000, 0, 0, 1, "R2");
      n = 0;
      for (int i = 0; i < 8; i++) begin
        step(0, 0, 0, 0, 0, 1, "R2");
        n++;
        if (popped) break;
      end
      check(n == 3, "R2", n, 3);
    end
    drain();

    // R3: gain codes over a full-range current sweep, bypass mode
    for (int g = 0; g < 4; g++)
      for (int k = 0; k < 24; k++)
        step(1, -32768 + k * 2849, 12000 - k * 1000, g, 0, 1, "R3");
    drain();

    // R4: DC-laden current with the high-pass stage on
    for (int k = 0; k < 80; k++)
      step(1, 3000 + (k % 5) * 40, 5000, 0, 1, 1, "R4");
    drain();

    // R5: alternating current where interpolation matters
    for (int k = 0; k < 40; k++)
      step(1, (k % 2 == 0) ? 8000 : -6000, (k % 3) * 4000 - 4000, 1, 1, 1, "R5");
    drain();

    // R6: steady product settles through the low-pass stage
    for (int k = 0; k < 60; k++)
      step(1, (k < 30) ? 20000 : -15000, -30000, 0, 0, 1, "R6");
    drain();

    // R9: random bubbles, stalls and per-pair mode changes
    for (int k = 0; k < 600; k++) begin
      bit iv, ordy, hp;
      int x, v, g;
      rng = nxt(rng); iv = rng[0] | rng[1];
      rng = nxt(rng); ordy = rng[3] | rng[5];
      rng = nxt(rng); x = int'($signed(rng[15:0]));
      rng = nxt(rng); v = int'($signed(rng[15:0]));
      rng = nxt(rng); g = int'(rng[1:0]); hp = rng[7];
      step(iv, x, v, g, hp, ordy, "R9");
    end
    drain();

    // R7: reset with pairs in flight and a stalled output
    for (int k = 0; k < 5; k++) step(1, 9000, 9000, 3, 1, 0, "R7");
    do_reset();
    step(1, 100, 300, 1, 0, 1, "R7");
    drain();

    finish_run();
  end

endmodule